// File: doc/BRIEF.md
# Multichannel Serial ADC Sequencer

This block sits between on-chip logic and an external 8-channel, 8-bit converter that talks over a four-wire serial link. A requester asks for one channel with a 3-bit number. The block then opens a 14-clock frame. During that frame it shifts out a command word that wakes the converter and selects the channel, and it collects the eight result bits that come back near the end of the frame. It then presents the result byte together with the channel on a one-cycle valid strobe.

A per-request averaging flag makes the block run 2^N frames back to back on the same channel. It sums the returned codes and reports the sum divided by 2^N, with the remainder discarded. This smooths readings of a rail that sags under load. Code 0x00 corresponds to 0 V and code 0xFF to 3.3 V; turning codes into volts is left to the consumer.

The serial clock idles low. Its half period is a parameter counted in system clocks, and it must be set so that the link runs at no more than 600 kHz. The averaging exponent N is a parameter from 0 to 3.

Top module: `adcseq_top`

## Requirements
- R1: Each conversion is one frame in which the chip-select output stays low for exactly 14 rising serial-clock edges. The serial clock is low whenever chip select is high.
- R2: The first two command bits of every frame, sampled on rising edges 1 and 2, are both 1.
- R3: Command bits 3, 4 and 5 carry the channel as ch[0], then ch[2], then ch[1]. For example, channel 2 is sent as 0,0,1 and channel 4 as 0,1,0.
- R4: Command bits 6 through 14 are driven as 0.
- R5: The result byte is made of the input bits sampled on rising edges 7 through 14, most significant first. Input bits on edges 1 to 6 do not affect the result.
- R6: The data output changes only while the serial clock is low. Each high phase of the serial clock lasts exactly SCLK_HALF system clocks.
- R7: A result is reported as a one-cycle pulse on res_valid, with res_ch equal to the requested channel.
- R8: busy rises on the cycle after a request is accepted and falls on the same edge that raises res_valid. A request made while busy starts no frame and does not change the reported channel.
- R9: With req_avg high, the block runs 2^AVG_LOG2 frames on the requested channel and reports the sum of their codes shifted right by AVG_LOG2.
- R10: Out of reset, chip select is high, the serial clock and the data output are low, and busy and res_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request, accepted when busy is low |
| req_ch | input | 3 | Channel to convert |
| req_avg | input | 1 | 1 = averaged reading, 0 = single reading |
| busy | output | 1 | A request is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 3 | Channel of the reported result |
| res_data | output | 8 | Result code |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_mosi | output | 1 | Command bit to the converter |
| spi_miso | input | 1 | Result bit from the converter |

## Verification
The converter model drives nonzero values during the six leading bit times of every frame. A design that started capturing too early, or captured one bit late, would return a shifted or polluted byte. Channels 2 and 4 are requested on purpose, because a plain binary encoding of the select bits would swap them. Averaging is run with codes whose sum overflows 8 bits and does not divide evenly, which exposes a truncated accumulator or a missing shift. A second request is made in the middle of a frame; a design that accepted it would start an extra frame or report the wrong channel.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int FRAME_LEN = 14;
  localparam int RES_W = 8;
  localparam int CH_W = 3;
  localparam int LEAD_ONES = 2;
  localparam int RES_FIRST = 6;
  localparam int MAX_AVG_LOG2 = 3;
  localparam int SUM_W = RES_W + MAX_AVG_LOG2;

  function automatic logic [FRAME_LEN-1:0] cmd_word(input logic [CH_W-1:0] ch);
    return {2'b11, ch[0], ch[2], ch[1], 9'b0};
  endfunction

  function automatic logic [RES_W-1:0] avg_of(input logic [SUM_W-1:0] sum,
                                              input int unsigned sh);
    logic [SUM_W-1:0] t;
    t = sum >> sh;
    return t[RES_W-1:0];
  endfunction
endpackage

// File: rtl/adcseq_sclk_gen.sv
module adcseq_sclk_gen #(
  parameter int HALF = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || cnt == CW'(HALF - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  ch,
  input  logic             tick,
  input  logic             miso,
  output logic             active,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             done,
  output logic [RES_W-1:0] data
);
  logic                 phase;
  logic [3:0]           bit_idx;
  logic [FRAME_LEN-1:0] tx;
  logic [RES_W-1:0]     rx;
  logic [4:0]           rise_cnt;
  logic                 sclk_rise;

  assign sclk_rise = active && tick && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      bit_idx <= '0;
      tx      <= '0;
      rx      <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        phase   <= 1'b0;
        bit_idx <= '0;
        tx      <= cmd_word(ch);
        rx      <= '0;
      end else if (active && tick) begin
        if (!phase) begin
          phase <= 1'b1;
          if (bit_idx >= 4'(RES_FIRST)) rx <= {rx[RES_W-2:0], miso};
        end else begin
          phase <= 1'b0;
          if (bit_idx == 4'(FRAME_LEN - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            tx      <= {tx[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_cnt <= '0;
    else if (start && !active) rise_cnt <= '0;
    else if (sclk_rise) rise_cnt <= rise_cnt + 1'b1;
  end

  assign sclk = phase;
  assign cs_n = !active;
  assign mosi = active ? tx[FRAME_LEN-1] : 1'b0;
  assign data = rx;

  a_r1_fourteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rise_cnt == 5'(FRAME_LEN));
  a_r1_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  a_r2_leading_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx < 4'(LEAD_ONES)) |-> mosi);
  a_r6_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/adcseq_accum.sv
module adcseq_accum
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [RES_W-1:0] din,
  output logic [SUM_W-1:0] sum_next
);
  logic [SUM_W-1:0] sum_q;

  assign sum_next = sum_q + {{(SUM_W-RES_W){1'b0}}, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else if (clr) sum_q <= '0;
    else if (add) sum_q <= sum_next;
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int SCLK_HALF = 42,
  parameter int AVG_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_ch,
  input  logic             req_avg,
  output logic             busy,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_ch,
  output logic [RES_W-1:0] res_data,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int NCONV = 1 << AVG_LOG2;

  logic             busy_q, launch, avg_q, accept, last_conv;
  logic [CH_W-1:0]  ch_q;
  logic [3:0]       conv_cnt;
  logic             frame_active, tick, frame_done;
  logic [RES_W-1:0] frame_data;
  logic [SUM_W-1:0] sum_next;

  assign accept    = req_valid && !busy_q;
  assign last_conv = !avg_q || (conv_cnt == 4'(NCONV - 1));

  adcseq_sclk_gen #(.HALF(SCLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(frame_active), .tick(tick)
  );

  adcseq_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(launch), .ch(ch_q), .tick(tick),
    .miso(spi_miso), .active(frame_active), .sclk(spi_sclk),
    .cs_n(spi_cs_n), .mosi(spi_mosi), .done(frame_done), .data(frame_data)
  );

  adcseq_accum u_acc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .add(frame_done && busy_q),
    .din(frame_data), .sum_next(sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      launch    <= 1'b0;
      avg_q     <= 1'b0;
      ch_q      <= '0;
      conv_cnt  <= '0;
      res_valid <= 1'b0;
      res_ch    <= '0;
      res_data  <= '0;
    end else begin
      launch    <= 1'b0;
      res_valid <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        ch_q     <= req_ch;
        avg_q    <= req_avg;
        conv_cnt <= '0;
        launch   <= 1'b1;
      end else if (busy_q && frame_done) begin
        if (last_conv) begin
          busy_q    <= 1'b0;
          res_valid <= 1'b1;
          res_ch    <= ch_q;
          res_data  <= avg_q ? avg_of(sum_next, AVG_LOG2) : frame_data;
        end else begin
          conv_cnt <= conv_cnt + 1'b1;
          launch   <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;

  a_r8_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  a_r8_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
  a_r8_frames_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NLOG = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_avg = 1'b0, spi_miso = 1'b0;
  logic [2:0] req_ch = '0;
  logic busy, res_valid, spi_sclk, spi_cs_n, spi_mosi;
  logic [2:0] res_ch;
  logic [7:0] res_data;

  int checks = 0, errors = 0;
  int frames = 0, edge_n = 0, mosi_bad = 0, idle_bad = 0, hi_bad = 0;
  logic [13:0] cap;
  logic [13:0] cmd_log [0:31];
  int edges_log [0:31];
  logic [7:0] vals [0:31];
  time t_rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_top #(.SCLK_HALF(HALF), .AVG_LOG2(NLOG)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
    .req_avg(req_avg), .busy(busy), .res_valid(res_valid), .res_ch(res_ch),
    .res_data(res_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // converter model: six junk bits, then the code MSB first
  function automatic logic slave_bit(input int k);
    logic [13:0] w;
    w = {6'b101101, vals[frames % 32]};
    return (k < 14) ? w[13-k] : 1'b0;
  endfunction

  always @(negedge spi_cs_n) if (rst_n) begin
    edge_n = 0; cap = '0; spi_miso = slave_bit(0);
  end
  always @(posedge spi_sclk) if (rst_n) begin
    cap = {cap[12:0], spi_mosi}; edge_n++; t_rise = $time;
    if (spi_cs_n) idle_bad++;
  end
  always @(negedge spi_sclk) if (rst_n && !spi_cs_n) begin
    if ($time - t_rise != HALF*CLK_PERIOD) hi_bad++;
    spi_miso = slave_bit(edge_n);
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    cmd_log[frames % 32] = cap; edges_log[frames % 32] = edge_n; frames++;
  end
  always @(spi_mosi) if (rst_n && spi_sclk === 1'b1) mosi_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_res(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (res_valid) begin seen = 1; break; end
    end
  endtask

  task automatic request(input logic [2:0] ch, input logic avg);
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch; req_avg = avg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [2:0] sel_bits(input logic [2:0] ch);
    logic [2:0] s;
    s[2] = ch[0]; s[1] = ch[2]; s[0] = ch[1];
    return s;
  endfunction

  task automatic check_cmd(input int f, input logic [2:0] ch);
    logic [13:0] c;
    c = cmd_log[f % 32];
    chk(edges_log[f % 32] == 14, "R1 rising edges per frame", edges_log[f % 32], 14);
    chk(c[13:12] == 2'b11, "R2 leading ones", int'(c[13:12]), 3);
    chk(c[11:9] == sel_bits(ch), "R3 channel bit order", int'(c[11:9]), int'(sel_bits(ch)));
    chk(c[8:0] == 9'd0, "R4 trailing zeros", int'(c[8:0]), 0);
  endtask

  task automatic t_single(input logic [2:0] ch, input logic [7:0] v);
    int f0; bit seen;
    f0 = frames; vals[f0 % 32] = v;
    request(ch, 1'b0);
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    wait_res(seen);
    chk(seen, "R7 result strobe", int'(seen), 1);
    chk(res_data == v, "R5 result byte", res_data, v);
    chk(res_ch == ch, "R7 result channel", res_ch, ch);
    chk(busy == 1'b0, "R8 busy low with result", int'(busy), 0);
    chk(frames == f0 + 1, "R1 one frame", frames - f0, 1);
    check_cmd(f0, ch);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 pulse one cycle", int'(res_valid), 0);
  endtask

  task automatic t_busy_ignore();
    int f0; bit seen;
    f0 = frames; vals[f0 % 32] = 8'h5A;
    request(3'd3, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R8 busy mid frame", int'(busy), 1);
    request(3'd6, 1'b1);
    wait_res(seen);
    chk(res_ch == 3'd3, "R8 ignored request channel", res_ch, 3);
    chk(res_data == 8'h5A, "R8 ignored request data", res_data, 8'h5A);
    repeat (200) @(negedge clk);
    chk(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
    chk(spi_cs_n == 1'b1 && busy == 1'b0, "R8 idle after result", int'(busy), 0);
  endtask

  task automatic t_avg(input logic [2:0] ch, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, input logic [7:0] d);
    int f0, sum; bit seen;
    f0 = frames;
    vals[f0 % 32] = a; vals[(f0+1) % 32] = b; vals[(f0+2) % 32] = c; vals[(f0+3) % 32] = d;
    sum = int'(a) + int'(b) + int'(c) + int'(d);
    request(ch, 1'b1);
    wait_res(seen);
    chk(seen, "R9 averaged strobe", int'(seen), 1);
    chk(frames == f0 + 4, "R9 frame count", frames - f0, 4);
    chk(res_data == 8'(sum / 4), "R9 averaged value", res_data, sum / 4);
    chk(res_ch == ch, "R9 averaged channel", res_ch, ch);
    for (int k = 0; k < 4; k++) check_cmd(f0 + k, ch);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10 cs high in reset", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R10 sclk mosi low", int'(spi_sclk), 0);
    chk(busy == 1'b0 && res_valid == 1'b0, "R10 busy valid low", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_single(3'd2, 8'hA5);
    t_single(3'd4, 8'h3C);
    t_single(3'd7, 8'hFF);
    t_single(3'd0, 8'h00);
    t_single(3'd5, 8'h81);
    t_busy_ignore();
    t_avg(3'd5, 8'd10, 8'd20, 8'd30, 8'd41);
    t_avg(3'd6, 8'd255, 8'd255, 8'd255, 8'd254);
    chk(mosi_bad == 0, "R6 mosi moved while sclk high", mosi_bad, 0);
    chk(hi_bad == 0, "R6 sclk high width", hi_bad, 0);
    chk(idle_bad == 0, "R1 sclk edge outside frame", idle_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule